// File: doc/BRIEF.md
# Armed Framebuffer Burst Writer

The block moves framebuffer pixel words from a rendering pipeline into external memory. Words arrive on a valid/full producer interface and queue in a small FIFO. They leave as fixed 32-byte incrementing AXI write bursts, with one burst outstanding at a time. A 32-bit register bus lets software set the destination base address and choose what the block may write. While the arm bit is clear, nothing reaches memory. Canary mode writes a single 32-byte line at the base address, and full mode writes a whole 8 KiB frame. Software uses canary mode to prove the memory path before it allows a full frame.

Status reads show whether the engine is idle, along with two sticky flags: one for a non-OKAY write response and one for a dropped producer word. Two cumulative counters report bytes and bursts that memory has acknowledged. Writing the control register with arm going from 0 to 1 restarts the frame at the base address and clears both sticky flags.

Top module: `fb_burst_writer`

## Requirements
- R1: After reset, register offset 0x018 reads 0x2, offset 0x01C reads 0x8000_0000, offset 0x02C reads 0x1, and offsets 0x030 and 0x034 read 0.
- R2: While control bit 0 (arm) is 0, no write address is issued, even with pixel words queued.
- R3: With control = 0x3 (arm=1, canary=1), exactly one burst is issued, at the base address, and then the engine goes idle.
- R4: With control = 0x1 (arm=1, canary=0), 256 bursts are issued at addresses base + 32*k for k = 0..255, and then no further bursts.
- R5: Every burst is INCR (awburst=1) with awlen=3 and awsize=3 (four 8-byte beats). wlast is set on the fourth beat only. The beats carry the queued words in arrival order.
- R6: When arm is cleared, a burst already in flight completes, no new write address follows, and status bit 0 (idle) returns to 1.
- R7: A write response other than OKAY (bresp != 0) sets status bit 1. The bit holds until the next 0-to-1 arm write clears it.
- R8: A word presented while pix_full=1 is dropped and sets status bit 2. The bit holds until the next 0-to-1 arm write clears it.
- R9: Each accepted write response adds 32 to the byte counter (0x030) and 1 to the burst counter (0x034). This includes responses that report an error.
- R10: Writes to offsets 0x02C, 0x030 and 0x034 have no effect.
- R11: A 0-to-1 arm write restarts the burst sequence at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pix_valid | input | 1 | Producer word valid |
| pix_data | input | 64 | Producer pixel word |
| pix_full | output | 1 | FIFO full; a word offered while this is high is dropped |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write byte strobes, all set |
| m_wlast | output | 1 | Final beat of the burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The assertions assume that the memory side asserts bvalid only after it has taken the last beat of a burst, and that a response is never presented while bready is low. They make no assumption about how often awready and wready are high. The bench's memory model holds its ready lines low on a fixed irregular schedule, queues exactly one response per wlast, and keeps each response valid until it is accepted. Producer words are presented only when pix_full is low, except in the one scenario that deliberately forces drops.

// File: rtl/fbw_pkg.sv
// Package: shared types and register offsets of the framebuffer burst writer.
// Assumes byte offsets on an 8-bit register address bus.
package fbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_RESP = 2'd3
    } fbw_state_t;

    localparam logic [7:0] OFS_CTRL   = 8'h18;
    localparam logic [7:0] OFS_BASE   = 8'h1C;
    localparam logic [7:0] OFS_STATUS = 8'h2C;
    localparam logic [7:0] OFS_BYTES  = 8'h30;
    localparam logic [7:0] OFS_BURSTS = 8'h34;

    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned LINE_SHIFT = 5;
endpackage

// File: rtl/fbw_fifo.sv
// Module: fbw_fifo - input queue for producer words.
// A word offered while full is dropped and reported on drop. Reads are
// first-word fall-through (head is valid whenever empty is low).
// Assumes DEPTH is a power of two.
module fbw_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wp_q, rp_q;

    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[PW-1:0] == rp_q[PW-1:0]) && (wp_q[PW] != rp_q[PW]);
    assign drop  = push && full;
    assign head  = mem[rp_q[PW-1:0]];

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q[PW-1:0]] <= push_data;
    end

    // Advance the read and write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push && !full) wp_q <= wp_q + 1'b1;
            if (pop && !empty) rp_q <= rp_q + 1'b1;
        end
    end
endmodule

// File: rtl/fbw_regs.sv
// Module: fbw_regs - software register file: control, base, sticky flags, counters.
// A control write that sets arm while arm is clear produces the start pulse,
// which clears the sticky flags. A flag set in the same cycle wins over the clear.
module fbw_regs
    import fbw_pkg::*;
#(
    parameter logic [31:0] BASE_RST = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        idle,
    input  logic        resp_done,
    input  logic        resp_err,
    input  logic        drop,
    output logic        arm,
    output logic        canary,
    output logic [31:0] base,
    output logic        start,
    output logic        err_flag,
    output logic        ovf_flag
);
    logic [31:0] bytes_q, bursts_q;

    assign start = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0] && !arm;

    // Control and base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm    <= 1'b0;
            canary <= 1'b1;
            base   <= BASE_RST;
        end else if (reg_wr) begin
            if (reg_addr == OFS_CTRL) begin
                arm    <= reg_wdata[0];
                canary <= reg_wdata[1];
            end
            if (reg_addr == OFS_BASE) base <= reg_wdata;
        end
    end

    // Sticky flags: cleared by start, set by events (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (start)    err_flag <= 1'b0;
            if (resp_err) err_flag <= 1'b1;
            if (start)    ovf_flag <= 1'b0;
            if (drop)     ovf_flag <= 1'b1;
        end
    end

    // Acknowledged-traffic counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q  <= '0;
            bursts_q <= '0;
        end else if (resp_done) begin
            bytes_q  <= bytes_q + LINE_BYTES;
            bursts_q <= bursts_q + 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = {30'd0, canary, arm};
            OFS_BASE:   reg_rdata = base;
            OFS_STATUS: reg_rdata = {29'd0, ovf_flag, err_flag, idle};
            OFS_BYTES:  reg_rdata = bytes_q;
            OFS_BURSTS: reg_rdata = bursts_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fbw_burst.sv
// Module: fbw_burst - sequences one AXI write burst at a time.
// Phases run in the order address, data, response. Arm is sampled only while
// idle, so a burst that has started always finishes. A start pulse during a
// burst takes effect once the engine is idle again. The burst index counts
// acknowledged bursts since the last start.
module fbw_burst
    import fbw_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int BEATS        = 4,
    parameter int FRAME_BURSTS = 256,
    parameter int IDX_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              canary,
    input  logic              start,
    input  logic [31:0]       base,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic [31:0]       m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic              idle,
    output logic              resp_done,
    output logic              resp_err
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    fbw_state_t       state_q;
    logic [IDX_W-1:0] idx_q, idx_eff, limit;
    logic             clr_pend_q;
    logic [BEAT_W-1:0] beat_q;
    logic [31:0]      awaddr_q;
    logic             last_beat;

    assign idx_eff   = clr_pend_q ? '0 : idx_q;
    assign limit     = canary ? IDX_W'(1) : IDX_W'(FRAME_BURSTS);
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

    assign m_awaddr  = awaddr_q;
    assign m_awlen   = 8'(BEATS - 1);
    assign m_awsize  = 3'($clog2(DATA_W / 8));
    assign m_awburst = 2'b01;
    assign m_awvalid = (state_q == ST_ADDR);
    assign m_wvalid  = (state_q == ST_DATA) && !fifo_empty;
    assign m_wdata   = fifo_head;
    assign m_wstrb   = '1;
    assign m_wlast   = (state_q == ST_DATA) && last_beat;
    assign m_bready  = (state_q == ST_RESP);
    assign fifo_pop  = m_wvalid && m_wready;
    assign idle      = (state_q == ST_IDLE);
    assign resp_done = m_bready && m_bvalid;
    assign resp_err  = resp_done && (m_bresp != 2'b00);

    // Burst sequencer: address phase, then data beats, then response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            clr_pend_q <= 1'b0;
            beat_q     <= '0;
            awaddr_q   <= '0;
        end else begin
            if (start) clr_pend_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    idx_q      <= idx_eff;
                    clr_pend_q <= start;
                    if (arm && (idx_eff < limit)) begin
                        awaddr_q <= base + (32'(idx_eff) << LINE_SHIFT);
                        state_q  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (m_awready) begin
                        beat_q  <= '0;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fifo_pop) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) state_q <= ST_RESP;
                    end
                end
                default: begin
                    if (m_bvalid) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fb_burst_writer.sv
// Module: fb_burst_writer - top of the armed framebuffer burst writer.
// Connects the input FIFO, the register file and the burst sequencer.
// Assumes a 32-byte line holds a whole number of data beats.
module fb_burst_writer #(
    parameter int          DATA_W      = 64,
    parameter int          FRAME_BYTES = 8192,
    parameter int          FIFO_DEPTH  = 8,
    parameter logic [31:0] BASE_RST    = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                pix_valid,
    input  logic [DATA_W-1:0]   pix_data,
    output logic                pix_full,
    output logic [31:0]         m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready
);
    localparam int BEATS        = fbw_pkg::LINE_BYTES / (DATA_W / 8);
    localparam int FRAME_BURSTS = FRAME_BYTES / fbw_pkg::LINE_BYTES;
    localparam int IDX_W        = $clog2(FRAME_BURSTS + 1);

    logic              arm, canary, start, idle, resp_done, resp_err;
    logic              err_flag, ovf_flag, drop;
    logic              fifo_empty, fifo_pop;
    logic [31:0]       base;
    logic [DATA_W-1:0] fifo_head;

    fbw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(pix_valid), .push_data(pix_data),
        .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(pix_full), .drop(drop)
    );

    fbw_regs #(.BASE_RST(BASE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .idle(idle), .resp_done(resp_done), .resp_err(resp_err), .drop(drop),
        .arm(arm), .canary(canary), .base(base), .start(start),
        .err_flag(err_flag), .ovf_flag(ovf_flag)
    );

    fbw_burst #(.DATA_W(DATA_W), .BEATS(BEATS), .FRAME_BURSTS(FRAME_BURSTS), .IDX_W(IDX_W)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .canary(canary), .start(start), .base(base),
        .fifo_empty(fifo_empty), .fifo_head(fifo_head), .fifo_pop(fifo_pop),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .idle(idle), .resp_done(resp_done), .resp_err(resp_err)
    );
endmodule

// File: rtl/fbw_checker.sv
// Module: fbw_checker - protocol and flag properties, bound into fb_burst_writer.
// Assumes the memory side gives one response per burst, after the last beat.
module fbw_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              err_flag,
    input logic              ovf_flag,
    input logic              pix_valid,
    input logic              pix_full,
    input logic [31:0]       m_awaddr,
    input logic [7:0]        m_awlen,
    input logic [1:0]        m_awburst,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [1:0]        m_bresp,
    input logic              m_bvalid,
    input logic              m_bready
);
    localparam logic [7:0] LEN = 8'(32 / (DATA_W / 8) - 1);

    // R5: burst shape on every address phase
    assert_burst_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awlen == LEN) && (m_awburst == 2'b01));

    // R4: addresses are line aligned
    assert_aw_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awaddr[4:0] == 5'd0));

    // R5: address held until accepted
    assert_aw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R5: data held until accepted
    assert_w_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    // R2: a burst starts only when arm was set
    assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $past(arm));

    // R7: a non-OKAY response sets the error flag
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready && (m_bresp != 2'b00)) |=> err_flag);

    // R8: a dropped word sets the overflow flag
    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_full) |=> ovf_flag);
endmodule

bind fb_burst_writer fbw_checker #(.DATA_W(DATA_W)) u_fbw_checker (
    .clk(clk), .rst_n(rst_n), .arm(arm), .err_flag(err_flag), .ovf_flag(ovf_flag),
    .pix_valid(pix_valid), .pix_full(pix_full),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
);

// File: tb/tb_fb_burst_writer.sv
module tb_fb_burst_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [63:0] pix_data = '0;
    logic        pix_full;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awvalid, m_wlast, m_wvalid, m_bready;
    logic        m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [1:0]  m_bresp = 2'b00;
    logic [63:0] m_wdata;
    logic [7:0]  m_wstrb;

    fb_burst_writer dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int aw_cnt = 0, w_cnt = 0, b_cnt = 0, shape_bad = 0, last_bad = 0;
    int pend_b = 0, err_inj = 0, beat_in = 0, cyc = 0;
    int pseq = 0;
    bit b_done = 0;
    logic [31:0] aw_log [2048];
    logic [63:0] w_log  [4096];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory-side model: irregular ready patterns, one response per wlast.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            m_awready = (cyc % 3) != 0;
            m_wready  = (cyc % 5) != 2;
            if (b_done) begin m_bvalid = 1'b0; b_done = 0; end
            if (!m_bvalid && pend_b > 0) begin
                m_bvalid = 1'b1;
                m_bresp  = (err_inj > 0) ? 2'b10 : 2'b00;
                if (err_inj > 0) err_inj--;
                pend_b--;
            end
            #1;
            if (rst_n && m_awvalid && m_awready) begin
                if (m_awlen != 8'd3 || m_awsize != 3'd3 || m_awburst != 2'b01) shape_bad++;
                aw_log[aw_cnt] = m_awaddr;
                aw_cnt++;
            end
            if (rst_n && m_wvalid && m_wready) begin
                if (m_wlast != (beat_in == 3) || m_wstrb != 8'hFF) last_bad++;
                w_log[w_cnt] = m_wdata;
                w_cnt++;
                beat_in = (beat_in + 1) % 4;
                if (m_wlast) pend_b++;
            end
            if (rst_n && m_bvalid && m_bready) begin
                b_cnt++;
                b_done = 1;
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input int n, input bit ignore_full);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!ignore_full && pix_full) begin
                pix_valid = 1'b0;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_data  = {32'hC0DE0000, 32'(pseq)};
            pseq++;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_b(input int target);
        while (b_cnt < target) @(negedge clk);
        idle_wait(6);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(8'h18, v); chk("R1 ctrl reset", v, 32'h2);
        reg_read(8'h1C, v); chk("R1 base reset", v, 32'h8000_0000);
        reg_read(8'h2C, v); chk("R1 status reset", v, 32'h1);
        reg_read(8'h30, v); chk("R1 bytes reset", v, 32'h0);
        reg_read(8'h34, v); chk("R1 bursts reset", v, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        reg_write(8'h2C, 32'hFFFF_FFFF);
        reg_write(8'h30, 32'h1234_5678);
        reg_write(8'h34, 32'h8765_4321);
        reg_read(8'h2C, v); chk("R10 status unchanged", v, 32'h1);
        reg_read(8'h30, v); chk("R10 bytes unchanged", v, 32'h0);
        reg_read(8'h34, v); chk("R10 bursts unchanged", v, 32'h0);
        reg_read(8'h18, v); chk("R10 ctrl unchanged", v, 32'h2);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        push(4, 1'b0);
        idle_wait(40);
        chk("R2 no address while disarmed", 32'(aw_cnt), 32'd0);
        reg_read(8'h2C, v); chk("R2 idle while disarmed", v, 32'h1);
    endtask

    task automatic t_canary;
        logic [31:0] v;
        reg_write(8'h18, 32'h3);
        wait_b(1);
        idle_wait(30);
        chk("R3 one burst", 32'(aw_cnt), 32'd1);
        chk("R3 burst at base", aw_log[0], 32'h8000_0000);
        for (int i = 0; i < 4; i++)
            chk("R5 canary beat data", w_log[i][31:0], 32'(i));
        chk("R5 beat count", 32'(w_cnt), 32'd4);
        reg_read(8'h2C, v); chk("R3 idle after canary", v, 32'h1);
        reg_read(8'h30, v); chk("R9 bytes after canary", v, 32'd32);
        reg_read(8'h34, v); chk("R9 bursts after canary", v, 32'd1);
    endtask

    task automatic t_error;
        logic [31:0] v;
        reg_write(8'h18, 32'h2);
        err_inj = 1;
        push(4, 1'b0);
        reg_write(8'h18, 32'h3);
        wait_b(2);
        chk("R11 rearm restarts at base", aw_log[1], 32'h8000_0000);
        reg_read(8'h2C, v); chk("R7 error flag set", v, 32'h3);
        idle_wait(10);
        reg_read(8'h2C, v); chk("R7 error flag sticky", v, 32'h3);
        reg_read(8'h34, v); chk("R9 error response counted", v, 32'd2);
    endtask

    task automatic t_full;
        logic [31:0] v;
        int aw0, w0, s0, bad;
        aw0 = aw_cnt; w0 = w_cnt; s0 = pseq; bad = 0;
        reg_write(8'h18, 32'h2);
        reg_write(8'h1C, 32'h1000_0000);
        reg_write(8'h18, 32'h1);
        reg_read(8'h2C, v); chk("R7 rearm clears error", {31'd0, v[1]}, 32'h0);
        push(1024, 1'b0);
        wait_b(aw0 + 256);
        idle_wait(40);
        chk("R4 burst count", 32'(aw_cnt - aw0), 32'd256);
        for (int k = 0; k < 256; k++)
            if (aw_log[aw0 + k] !== 32'h1000_0000 + 32'(k * 32)) bad++;
        chk("R4 address sequence", 32'(bad), 32'd0);
        chk("R4 last address", aw_log[aw0 + 255], 32'h1000_1FE0);
        bad = 0;
        for (int k = 0; k < 1024; k++)
            if (w_log[w0 + k] !== {32'hC0DE0000, 32'(s0 + k)}) bad++;
        chk("R5 frame data order", 32'(bad), 32'd0);
        chk("R5 burst shape", 32'(shape_bad), 32'd0);
        chk("R5 wlast placement", 32'(last_bad), 32'd0);
        reg_read(8'h30, v); chk("R9 bytes after frame", v, 32'd8256);
        reg_read(8'h34, v); chk("R9 bursts after frame", v, 32'd258);
        reg_read(8'h2C, v); chk("R4 idle after frame", v, 32'h1);
    endtask

    task automatic t_disarm;
        logic [31:0] v;
        int aw0, a1, d;
        aw0 = aw_cnt;
        reg_write(8'h18, 32'h0);
        reg_write(8'h18, 32'h1);
        push(12, 1'b0);
        reg_write(8'h18, 32'h0);
        idle_wait(60);
        chk("R6 in-flight burst completed", 32'(b_cnt), 32'(aw_cnt));
        a1 = aw_cnt;
        d  = aw_cnt - aw0;
        chk("R6 stopped early", 32'((d >= 1) && (d <= 3)), 32'd1);
        idle_wait(40);
        chk("R6 no new address", 32'(aw_cnt), 32'(a1));
        reg_read(8'h2C, v); chk("R6 idle after disarm", v, 32'h1);
        reg_read(8'h34, v); chk("R9 bursts after disarm", v, 32'(258 + d));
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        int b0;
        b0 = b_cnt;
        push(12, 1'b1);
        reg_read(8'h2C, v); chk("R8 overflow flag set", v, 32'h5);
        chk("R8 fifo full after drops", 32'(pix_full), 32'd1);
        reg_write(8'h18, 32'h3);
        reg_read(8'h2C, v); chk("R8 rearm clears overflow", {31'd0, v[2]}, 32'h0);
        wait_b(b0 + 1);
        chk("R11 rearm at base", aw_log[aw_cnt - 1], 32'h1000_0000);
        chk("R8 space after drain", 32'(pix_full), 32'd0);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000; wd++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_wait(4);
        rst_n = 1'b1;
        idle_wait(2);
        t_reset();
        t_readonly();
        t_hold();
        t_canary();
        t_error();
        t_full();
        t_disarm();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule